// File: doc/BRIEF.md
# DMA Channel Enable and Interrupt Register Block

This block is the control and interrupt register file of a DMA controller with up to eight channels. Software writes a global enable bit to switch the controller on, then starts and stops channels one at a time. Each channel enable bit has a paired write-enable bit eight positions higher, so one store changes exactly the chosen channels and needs no read-modify-write. The same paired scheme is used by every interrupt mask register. The data movers outside this block raise a channel's enable bit's "finished" input when the channel is done, and the block drops that enable bit by itself.

Five interrupt classes are tracked per channel: transfer done, block done, source transaction, destination transaction and error. Each class keeps a raw latch per channel, set by a one-cycle event pulse, a mask bit (1 = the channel may interrupt), and a write-one-to-clear register. The transfer, block and error classes also have readable raw and masked-status registers. A summary register gives one bit per class, and a single interrupt output is high while any masked bit is set. Register reads are combinational on the address; every register changes on the rising clock edge.

Top module: `dmac_chan_irq_regs`

## Requirements
- R1: While reset is low and in the first cycle after it, every raw bit, every mask bit, every channel enable and the global enable are 0, so `ch_en` is 0 and `irq` is low.
- R2: Bit 0 of the word at 0x398 is the global enable and reads back (other bits read 0). While the new global value is 0, channel enable writes are ignored and all enables are 0; writing 0 clears every enable at that same clock edge.
- R3: A write to 0x3A0 changes enable bit n (bits 0..7) only when bit n+8 of the written data is 1, taking the value of bit n; the read of 0x3A0 returns the enables in bits 0..7 and 0 in all higher bits, and `ch_en` shows the same enables.
- R4: A high `ch_done[n]` clears enable bit n at the next edge, even when a write in the same cycle tries to set it.
- R5: An event pulse on bit n of a class input sets raw bit n of that class at the next edge; raw transfer, block and error bits read at 0x2C0, 0x2C8 and 0x2E0 in bits 0..7.
- R6: The mask registers are at 0x310 (transfer), 0x318 (block), 0x320 (source), 0x328 (destination) and 0x330 (error); a write changes mask bit n only when bit n+8 is 1, writing bit n+8 alone masks channel n, and reads return the masks in bits 0..7 with 0 above.
- R7: The status registers at 0x2E8 (transfer), 0x2F0 (block) and 0x308 (error) read the raw bits ANDed with the mask bits of their class.
- R8: The clear registers at 0x338, 0x340, 0x348, 0x350 and 0x358 (same class order as the masks) clear raw bit n for each written 1 in bit n; they read as 0, and an event on the same bit in the same cycle keeps the raw bit set.
- R9: The word at 0x360 returns in bits 0..4 the OR of the masked bits of transfer, block, source, destination and error respectively, 0 above; unmapped addresses read 0.
- R10: `irq` is high exactly while at least one masked raw bit of any class is set.
- R11: The source and destination classes have no raw or status address; their events are seen only through 0x360 and `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte offset of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_tfr | input | NUM_CH | Transfer-done event pulses, one per channel |
| ev_blk | input | NUM_CH | Block-done event pulses |
| ev_src | input | NUM_CH | Source transaction event pulses |
| ev_dst | input | NUM_CH | Destination transaction event pulses |
| ev_err | input | NUM_CH | Error event pulses |
| ch_done | input | NUM_CH | Channel-finished pulses that drop the enable bit |
| ch_en | output | NUM_CH | Current channel enables |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions take every input to be a known value on each rising edge after reset and `reg_addr` to be the byte offset of an aligned word, so an address matches at most one register. They take no protocol on the events: a pulse may repeat, may hit a channel that is disabled and may collide with a clear or a write. The bench drives all inputs at falling edges from one script with no unknown values, forces the collisions on purpose (finish against enable write, event against clear), and then mixes random reads, writes and sparse events over every mapped address plus unmapped ones.

// File: rtl/dmac_regs_pkg.sv
// Shared constants for the DMA channel enable and interrupt register block.
// Assumes byte offsets of 32-bit words; class index order is fixed and
// is also the bit order of the combined status word.
package dmac_regs_pkg;
    localparam int NUM_CLASS = 5;
    localparam int CLS_TFR   = 0;
    localparam int CLS_BLK   = 1;
    localparam int CLS_SRC   = 2;
    localparam int CLS_DST   = 3;
    localparam int CLS_ERR   = 4;
    localparam int WE_POS    = 8;   // distance from a bit to its write-enable

    localparam int OFS_RAW_TFR  = 'h2C0;
    localparam int OFS_RAW_BLK  = 'h2C8;
    localparam int OFS_RAW_ERR  = 'h2E0;
    localparam int OFS_STA_TFR  = 'h2E8;
    localparam int OFS_STA_BLK  = 'h2F0;
    localparam int OFS_STA_ERR  = 'h308;
    localparam int OFS_COMBINED = 'h360;
    localparam int OFS_GLOBAL   = 'h398;
    localparam int OFS_CHAN_EN  = 'h3A0;

    // Mask registers sit on an 8-byte stride in class order.
    function automatic int mask_ofs(input int cls);
        return 'h310 + 8 * cls;
    endfunction

    // Clear registers follow the masks with the same stride and order.
    function automatic int clear_ofs(input int cls);
        return 'h338 + 8 * cls;
    endfunction
endpackage

// File: rtl/dmac_irq_class.sv
// One interrupt class: per-channel raw latches, paired-write mask and
// write-one-to-clear. Assumes wr_lo/wr_we are data bits [N-1:0] and
// [N+7:8]. An event beats a clear on the same bit in the same cycle.
module dmac_irq_class #(
    parameter int NUM_CH    = 8,
    parameter int ADDR_W    = 10,
    parameter int MASK_ADDR = 'h310,
    parameter int CLR_ADDR  = 'h338
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NUM_CH-1:0] wr_lo,
    input  logic [NUM_CH-1:0] wr_we,
    input  logic [NUM_CH-1:0] ev,
    output logic [NUM_CH-1:0] raw_q,
    output logic [NUM_CH-1:0] mask_q,
    output logic [NUM_CH-1:0] stat,
    output logic              any
);
    logic              mask_hit;
    logic              clr_hit;
    logic [NUM_CH-1:0] clr_bits;
    logic [NUM_CH-1:0] raw_d;
    logic [NUM_CH-1:0] mask_d;

    // Decode the two addresses this class owns.
    always_comb begin
        mask_hit = reg_wr && (reg_addr == ADDR_W'(MASK_ADDR));
        clr_hit  = reg_wr && (reg_addr == ADDR_W'(CLR_ADDR));
    end

    // Next raw and mask values: events set, clears drop, paired writes.
    always_comb begin
        clr_bits = clr_hit ? wr_lo : '0;
        raw_d    = (raw_q & ~clr_bits) | ev;
        mask_d   = mask_hit ? ((mask_q & ~wr_we) | (wr_lo & wr_we)) : mask_q;
    end

    // State registers, all cleared by reset so the class starts masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q  <= raw_d;
            mask_q <= mask_d;
        end
    end

    // Masked view and its reduction for the summary word.
    always_comb begin
        stat = raw_q & mask_q;
        any  = |stat;
    end
endmodule

// File: rtl/dmac_chan_enable.sv
// Global enable and per-channel enables with paired write-enable bits.
// Assumes a channel-finished pulse outranks a same-cycle write, and a
// global value of 0 (including one being written) forces all enables off.
module dmac_chan_enable #(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 10,
    parameter int GLOBAL_ADDR = 'h398,
    parameter int CHEN_ADDR   = 'h3A0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_glob,
    input  logic [NUM_CH-1:0] wr_lo,
    input  logic [NUM_CH-1:0] wr_we,
    input  logic [NUM_CH-1:0] ch_done,
    output logic              glob_q,
    output logic [NUM_CH-1:0] en_q
);
    logic              glob_hit;
    logic              chen_hit;
    logic              glob_d;
    logic [NUM_CH-1:0] en_wr;
    logic [NUM_CH-1:0] en_d;

    // Decode the global and channel-enable words.
    always_comb begin
        glob_hit = reg_wr && (reg_addr == ADDR_W'(GLOBAL_ADDR));
        chen_hit = reg_wr && (reg_addr == ADDR_W'(CHEN_ADDR));
    end

    // Next enables: paired write, then finish pulses, gated by global.
    always_comb begin
        glob_d = glob_hit ? wr_glob : glob_q;
        en_wr  = chen_hit ? ((en_q & ~wr_we) | (wr_lo & wr_we)) : en_q;
        en_d   = glob_d ? (en_wr & ~ch_done) : '0;
    end

    // State registers, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_q <= 1'b0;
            en_q   <= '0;
        end else begin
            glob_q <= glob_d;
            en_q   <= en_d;
        end
    end
endmodule

// File: rtl/dmac_chan_irq_regs.sv
// Top of the DMA channel enable and interrupt register block. Builds one
// interrupt class per event kind, the enable logic and the read mux.
// Assumes NUM_CH is 1..8 (write-enables live at bits NUM_CH+7:8) and that
// reg_addr is a word-aligned byte offset at least 10 bits wide.
module dmac_chan_irq_regs
    import dmac_regs_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_CH-1:0] ev_tfr,
    input  logic [NUM_CH-1:0] ev_blk,
    input  logic [NUM_CH-1:0] ev_src,
    input  logic [NUM_CH-1:0] ev_dst,
    input  logic [NUM_CH-1:0] ev_err,
    input  logic [NUM_CH-1:0] ch_done,
    output logic [NUM_CH-1:0] ch_en,
    output logic              irq
);
    logic [NUM_CH-1:0]                  wr_lo;
    logic [NUM_CH-1:0]                  wr_we;
    logic                               unused_wdata;
    logic [NUM_CLASS-1:0][NUM_CH-1:0]   cls_ev;
    logic [NUM_CLASS-1:0][NUM_CH-1:0]   cls_raw;
    logic [NUM_CLASS-1:0][NUM_CH-1:0]   cls_mask;
    logic [NUM_CLASS-1:0][NUM_CH-1:0]   cls_stat;
    logic [NUM_CLASS-1:0]               cls_any;
    logic                               glob_q;

    // Split the write word into value and write-enable halves.
    assign wr_lo        = reg_wdata[NUM_CH-1:0];
    assign wr_we        = reg_wdata[WE_POS +: NUM_CH];
    assign unused_wdata = ^reg_wdata;

    // Gather event inputs in class order.
    assign cls_ev[CLS_TFR] = ev_tfr;
    assign cls_ev[CLS_BLK] = ev_blk;
    assign cls_ev[CLS_SRC] = ev_src;
    assign cls_ev[CLS_DST] = ev_dst;
    assign cls_ev[CLS_ERR] = ev_err;

    // One interrupt class per event kind.
    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_cls
        dmac_irq_class #(
            .NUM_CH    (NUM_CH),
            .ADDR_W    (ADDR_W),
            .MASK_ADDR (mask_ofs(g)),
            .CLR_ADDR  (clear_ofs(g))
        ) i_cls (
            .clk      (clk),
            .rst_n    (rst_n),
            .reg_wr   (reg_wr),
            .reg_addr (reg_addr),
            .wr_lo    (wr_lo),
            .wr_we    (wr_we),
            .ev       (cls_ev[g]),
            .raw_q    (cls_raw[g]),
            .mask_q   (cls_mask[g]),
            .stat     (cls_stat[g]),
            .any      (cls_any[g])
        );
    end

    dmac_chan_enable #(
        .NUM_CH      (NUM_CH),
        .ADDR_W      (ADDR_W),
        .GLOBAL_ADDR (OFS_GLOBAL),
        .CHEN_ADDR   (OFS_CHAN_EN)
    ) i_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .wr_glob  (reg_wdata[0]),
        .wr_lo    (wr_lo),
        .wr_we    (wr_we),
        .ch_done  (ch_done),
        .glob_q   (glob_q),
        .en_q     (ch_en)
    );

    // Combined interrupt from all class summaries.
    assign irq = |cls_any;

    // Read mux: fixed words first, then the strided mask words.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_RAW_TFR))  reg_rdata[NUM_CH-1:0] = cls_raw[CLS_TFR];
        if (reg_addr == ADDR_W'(OFS_RAW_BLK))  reg_rdata[NUM_CH-1:0] = cls_raw[CLS_BLK];
        if (reg_addr == ADDR_W'(OFS_RAW_ERR))  reg_rdata[NUM_CH-1:0] = cls_raw[CLS_ERR];
        if (reg_addr == ADDR_W'(OFS_STA_TFR))  reg_rdata[NUM_CH-1:0] = cls_stat[CLS_TFR];
        if (reg_addr == ADDR_W'(OFS_STA_BLK))  reg_rdata[NUM_CH-1:0] = cls_stat[CLS_BLK];
        if (reg_addr == ADDR_W'(OFS_STA_ERR))  reg_rdata[NUM_CH-1:0] = cls_stat[CLS_ERR];
        if (reg_addr == ADDR_W'(OFS_COMBINED)) reg_rdata[NUM_CLASS-1:0] = cls_any;
        if (reg_addr == ADDR_W'(OFS_GLOBAL))   reg_rdata[0] = glob_q;
        if (reg_addr == ADDR_W'(OFS_CHAN_EN))  reg_rdata[NUM_CH-1:0] = ch_en;
        for (int c = 0; c < NUM_CLASS; c++) begin
            if (reg_addr == ADDR_W'(mask_ofs(c))) reg_rdata[NUM_CH-1:0] = cls_mask[c];
        end
    end
endmodule

// File: rtl/dmac_chan_irq_regs_chk.sv
// Checker for the register block, attached by bind. Assumes known inputs
// after reset and word-aligned byte addresses.
module dmac_chan_irq_regs_chk
    import dmac_regs_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 10
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             reg_wr,
    input logic [ADDR_W-1:0]                reg_addr,
    input logic [31:0]                      reg_wdata,
    input logic [31:0]                      reg_rdata,
    input logic [NUM_CH-1:0]                ev_tfr,
    input logic [NUM_CH-1:0]                ch_done,
    input logic [NUM_CH-1:0]                ch_en,
    input logic                             irq,
    input logic [NUM_CLASS-1:0][NUM_CH-1:0] cls_raw,
    input logic [NUM_CLASS-1:0][NUM_CH-1:0] cls_mask
);
    logic cfg_off_wr;
    logic chen_nowe_wr;
    logic clr_rd;
    logic unused_chk;

    // Decode the stimulus patterns the properties key on.
    always_comb begin
        cfg_off_wr   = reg_wr && (reg_addr == ADDR_W'(OFS_GLOBAL)) && !reg_wdata[0];
        chen_nowe_wr = reg_wr && (reg_addr == ADDR_W'(OFS_CHAN_EN))
                       && (reg_wdata[WE_POS +: NUM_CH] == '0);
        clr_rd = 1'b0;
        for (int c = 0; c < NUM_CLASS; c++) begin
            if (reg_addr == ADDR_W'(clear_ofs(c))) clr_rd = 1'b1;
        end
        unused_chk = ^reg_wdata;
    end

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ch_en == '0 && !irq)); // R1

    AST_GLOBAL_OFF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_off_wr |=> (ch_en == '0)); // R2

    AST_WE_GATES_CHEN: assert property (@(posedge clk) disable iff (!rst_n)
        chen_nowe_wr |=> (ch_en == ($past(ch_en) & ~$past(ch_done)))); // R3

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_done != '0) |=> ((ch_en & $past(ch_done)) == '0)); // R4

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tfr != '0) |=> ((cls_raw[CLS_TFR] & $past(ev_tfr)) == $past(ev_tfr))); // R8

    AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rd |-> (reg_rdata == '0)); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_mask == '0) |-> !irq); // R10
endmodule

bind dmac_chan_irq_regs dmac_chan_irq_regs_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ev_tfr    (ev_tfr),
    .ch_done   (ch_done),
    .ch_en     (ch_en),
    .irq       (irq),
    .cls_raw   (cls_raw),
    .cls_mask  (cls_mask)
);

// File: tb/test_dmac_chan_irq_regs.sv
// Bench: behavioural reference model updated on each rising edge and
// compared with read data, ch_en and irq one ns after each falling edge.
module test_dmac_chan_irq_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0][7:0] ev_all = '0;
    logic [7:0]  ch_done = '0;
    logic [7:0]  ch_en;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc_cnt = 0;
    bit armed = 0;
    bit ended = 0;
    string cur_req = "R1";

    // Model state
    logic [4:0][7:0] m_raw = '0;
    logic [4:0][7:0] m_mask = '0;
    logic [7:0] m_en = '0;
    logic m_glob = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dmac_chan_irq_regs i_dmac_chan_irq_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_tfr(ev_all[0]), .ev_blk(ev_all[1]), .ev_src(ev_all[2]),
        .ev_dst(ev_all[3]), .ev_err(ev_all[4]),
        .ch_done(ch_done), .ch_en(ch_en), .irq(irq)
    );

    function automatic int mofs(input int c); return 'h310 + 8 * c; endfunction
    function automatic int cofs(input int c); return 'h338 + 8 * c; endfunction

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        cyc_cnt++;
        if (!rst_n) begin
            m_raw = '0; m_mask = '0; m_en = '0; m_glob = 1'b0;
        end else begin
            for (int c = 0; c < 5; c++) begin
                for (int n = 0; n < 8; n++) begin
                    if (ev_all[c][n]) m_raw[c][n] = 1'b1;
                    else if (reg_wr && int'(reg_addr) == cofs(c) && reg_wdata[n]) m_raw[c][n] = 1'b0;
                    if (reg_wr && int'(reg_addr) == mofs(c) && reg_wdata[n+8]) m_mask[c][n] = reg_wdata[n];
                end
            end
            if (reg_wr && int'(reg_addr) == 'h398) m_glob = reg_wdata[0];
            for (int n = 0; n < 8; n++) begin
                if (!m_glob || ch_done[n]) m_en[n] = 1'b0;
                else if (reg_wr && int'(reg_addr) == 'h3A0 && reg_wdata[n+8]) m_en[n] = reg_wdata[n];
            end
        end
    end

    function automatic logic [31:0] exp_rd(input int a);
        logic [31:0] r = '0;
        case (a)
            'h2C0: r[7:0] = m_raw[0];
            'h2C8: r[7:0] = m_raw[1];
            'h2E0: r[7:0] = m_raw[4];
            'h2E8: r[7:0] = m_raw[0] & m_mask[0];
            'h2F0: r[7:0] = m_raw[1] & m_mask[1];
            'h308: r[7:0] = m_raw[4] & m_mask[4];
            'h360: for (int c = 0; c < 5; c++) r[c] = |(m_raw[c] & m_mask[c]);
            'h398: r[0] = m_glob;
            'h3A0: r[7:0] = m_en;
            default: for (int c = 0; c < 5; c++) if (a == mofs(c)) r[7:0] = m_mask[c];
        endcase
        return r;
    endfunction

    function automatic string req_of(input int a);
        if (a == 'h2C0 || a == 'h2C8 || a == 'h2E0) return "R5";
        if (a == 'h2E8 || a == 'h2F0 || a == 'h308) return "R7";
        if (a >= 'h310 && a <= 'h330) return "R6";
        if (a >= 'h338 && a <= 'h358) return "R8";
        if (a == 'h360) return "R9";
        if (a == 'h398) return "R2";
        if (a == 'h3A0) return "R3";
        return "R9";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h t=%0t", tag, reg_addr, act, exp, $time);
        end
    endtask

    // Compare outputs with the model between edges.
    always @(negedge clk) begin
        #1;
        if (armed && !ended) begin
            string tag;
            tag = (cur_req != "") ? cur_req : req_of(int'(reg_addr));
            check(tag, reg_rdata, exp_rd(int'(reg_addr)));
            check("R10 irq", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
            check("R4 ch_en", {24'd0, ch_en}, {24'd0, m_en});
        end
    end

    task automatic step(input logic wr, input int a, input logic [31:0] d,
                        input logic [4:0][7:0] ev, input logic [7:0] dn);
        @(negedge clk);
        reg_wr = wr; reg_addr = 10'(a); reg_wdata = d; ev_all = ev; ch_done = dn;
    endtask
    task automatic wr_reg(input int a, input logic [31:0] d); step(1'b1, a, d, '0, '0); endtask
    task automatic rd_reg(input int a); step(1'b0, a, 32'd0, '0, '0); endtask

    function automatic int rnd_addr(input int k);
        case (k)
            0: return 'h2C0;  1: return 'h2C8;  2: return 'h2E0;  3: return 'h2E8;
            4: return 'h2F0;  5: return 'h308;  6: return 'h310;  7: return 'h318;
            8: return 'h320;  9: return 'h328;  10: return 'h330; 11: return 'h338;
            12: return 'h340; 13: return 'h348; 14: return 'h350; 15: return 'h358;
            16: return 'h360; 17: return 'h398; 18: return 'h3A0; default: return 'h3F8;
        endcase
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        #(200000 * 4);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not end actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [4:0][7:0] ev;
        // R1: reset state
        cur_req = "R1";
        rd_reg('h3A0);
        rd_reg('h310);
        armed = 1;
        rd_reg('h2C0);
        rd_reg('h398);
        @(negedge clk); rst_n = 1'b1;
        rd_reg('h3A0);
        // R2: enables held off while the global bit is 0
        cur_req = "R2";
        wr_reg('h3A0, 32'h0000_FFFF);
        rd_reg('h3A0);
        wr_reg('h398, 32'hFFFF_FFFF);
        rd_reg('h398);
        wr_reg('h3A0, 32'h0000_FFFF);
        rd_reg('h3A0);
        wr_reg('h398, 32'h0000_0000);
        rd_reg('h3A0);
        wr_reg('h398, 32'h0000_0001);
        // R3: paired write-enable
        cur_req = "R3";
        wr_reg('h3A0, 32'hFFFF_0F0F);
        rd_reg('h3A0);
        wr_reg('h3A0, 32'h0000_0200);
        rd_reg('h3A0);
        wr_reg('h3A0, 32'h0000_00F0);
        rd_reg('h3A0);
        wr_reg('h3A0, 32'h0000_8080);
        rd_reg('h3A0);
        // R4: finish beats a same-cycle enable write
        cur_req = "R4";
        step(1'b1, 'h3A0, 32'h0000_0404, '0, 8'h04);
        rd_reg('h3A0);
        step(1'b0, 'h3A0, 32'd0, '0, 8'h09);
        rd_reg('h3A0);
        // R5: events set raw bits
        cur_req = "R5";
        ev = '0; ev[0] = 8'h81; ev[1] = 8'h42; ev[4] = 8'h10;
        step(1'b0, 'h2C0, 32'd0, ev, '0);
        rd_reg('h2C0); rd_reg('h2C8); rd_reg('h2E0);
        // R6: masks
        cur_req = "R6";
        for (int c = 0; c < 5; c++) wr_reg(mofs(c), 32'h0000_FF83);
        for (int c = 0; c < 5; c++) rd_reg(mofs(c));
        wr_reg(mofs(0), 32'h0000_0200);
        wr_reg(mofs(1), 32'h0000_00FF);
        rd_reg(mofs(0)); rd_reg(mofs(1));
        // R7: status
        cur_req = "R7";
        rd_reg('h2E8); rd_reg('h2F0); rd_reg('h308);
        // R9: combined
        cur_req = "R9";
        rd_reg('h360);
        rd_reg('h3F8);
        // R11: source/destination only via summary and irq
        cur_req = "R11";
        ev = '0; ev[2] = 8'h01; ev[3] = 8'h02;
        step(1'b0, 'h360, 32'd0, ev, '0);
        rd_reg('h360);
        wr_reg('h338, 32'h0000_00FF); wr_reg('h340, 32'hFF); wr_reg('h358, 32'hFF);
        rd_reg('h360);
        wr_reg('h348, 32'h0000_0001);
        rd_reg('h360);
        wr_reg('h350, 32'h0000_0002);
        rd_reg('h360);
        // R8: clears, event beats clear, clear words read 0
        cur_req = "R8";
        ev = '0; ev[0] = 8'h03;
        step(1'b0, 'h2C0, 32'd0, ev, '0);
        ev = '0; ev[0] = 8'h01;
        step(1'b1, 'h338, 32'h0000_0003, ev, '0);
        rd_reg('h2C0);
        for (int c = 0; c < 5; c++) rd_reg(cofs(c));
        // R10: irq follows masked bits
        cur_req = "R10";
        wr_reg(mofs(0), 32'h0000_0100);
        rd_reg('h360);
        wr_reg(mofs(0), 32'h0000_0101);
        rd_reg('h360);
        // Random mix over all addresses
        cur_req = "";
        for (int i = 0; i < 3000; i++) begin
            int a;
            logic [31:0] d;
            logic [7:0] dn;
            a = rnd_addr(int'($urandom % 20));
            d = $urandom;
            if (a == 'h398) d[0] = (($urandom % 4) != 0);
            for (int c = 0; c < 5; c++) ev[c] = 8'($urandom & $urandom & $urandom);
            dn = 8'($urandom & $urandom & $urandom & $urandom);
            step(1'($urandom % 2), a, d, ev, dn);
        end
        rd_reg('h3A0);
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule